// File: doc/BRIEF.md
# RF Overpower Trip Interlock

This block is the fast shutdown decision for one RF station. During the RF gate it watches a set of RF power samples. Each channel has its own threshold and its own time limit. A channel faults once its sample has stayed above its threshold for more consecutive gate cycles than its limit allows. The block also takes arc detector inputs and software interlock requests, each with its own enable bit. A vacuum-OK input has no enable and always acts.

Any fault that is present sets a latched trip. The trip is driven on two independent output lines so that the drive stage can remove the RF drive on either one. The source of the first fault is stored as a code, and the code is held until the trip is cleared. An explicit clear releases the trip only when no enabled fault is present in that cycle.

Top module: `rf_trip_interlock`

## Requirements
- R1: With the gate high, an enabled channel faults in the cycle that its sample has been above its threshold for more than its limit of consecutive cycles. The trip outputs are high after that clock edge. A limit of 3 trips after the 4th consecutive sample above threshold, and a limit of 0 trips after the first.
- R2: A sample equal to or below the threshold resets that channel's run count to zero. Earlier cycles above threshold then no longer count towards the limit.
- R3: While the gate is low no channel can fault, whatever the power levels. A low gate cycle also resets every run count.
- R4: A channel whose enable bit is 0 never causes a trip. Its run count keeps advancing, so setting the enable bit while the run is still going trips it at once if the run already exceeds the limit.
- R5: An arc input that is high trips the block only while its enable bit is 1.
- R6: A software interlock request that is high trips the block only while its enable bit is 1.
- R7: vac_ok_i low trips the block after the next clock edge, whatever the enable settings.
- R8: The trip stays set until clear_i is high in a cycle with no enabled fault present. A clear in a cycle that has an enabled fault has no effect.
- R9: trip_a_o and trip_b_o come from separate flip-flops and always carry the same value.
- R10: cause_o is 0 while the block is not tripped. In the trip cycle it captures the code of the fault source: 1 for vacuum, 2+k for channel k, 10+j for arc j, 24+s for software request s. When several sources fault in the same cycle, the lowest code wins. The code holds until the trip is cleared, and later faults do not change it.
- R11: After reset both trip lines and cause_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| gate_i | input | 1 | RF gate; power monitoring only while high |
| pwr_i | input | N_CH*PWR_W | Power samples, channel k at bits k*PWR_W |
| thresh_i | input | N_CH*PWR_W | Per-channel thresholds |
| limit_i | input | N_CH*TMR_W | Per-channel allowed cycles above threshold |
| ch_en_i | input | N_CH | Channel enables |
| arc_i | input | N_ARC | Arc detector inputs, active high |
| arc_en_i | input | N_ARC | Arc enables |
| sw_i | input | N_SW | Software interlock requests, active high |
| sw_en_i | input | N_SW | Software request enables |
| vac_ok_i | input | 1 | Vacuum good; low forces a trip |
| clear_i | input | 1 | Trip clear request |
| trip_a_o | output | 1 | Latched trip, line A |
| trip_b_o | output | 1 | Latched trip, line B |
| cause_o | output | CW | First-fault code, 0 when not tripped |

## Verification
The hardest case to reach is a disabled channel whose run count has already passed its limit at the moment its enable is set. Only then does R4's claim, that counting goes on while the channel is masked, become visible at the trip output. The stimulus holds a masked channel above threshold for many gate cycles and then sets the enable with the gate still high. It also checks cleared runs: a single sample exactly at threshold, and a one-cycle gate drop, each placed inside a run that would otherwise have exceeded its limit. A behavioural model advanced in step with the clock compares both trip lines and the cause code on every cycle.

// File: rtl/rf_trip_pkg.sv
package rf_trip_pkg;
  localparam int unsigned N_CH_DEF  = 8;
  localparam int unsigned N_ARC_DEF = 14;
  localparam int unsigned N_SW_DEF  = 4;

  function automatic int unsigned code_w(input int unsigned n_src);
    return $clog2(n_src + 1);
  endfunction
endpackage

// File: rtl/rf_trip_chan.sv
module rf_trip_chan #(
  parameter int unsigned PWR_W = 12,
  parameter int unsigned TMR_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             gate_i,
  input  logic             en_i,
  input  logic [PWR_W-1:0] pwr_i,
  input  logic [PWR_W-1:0] thr_i,
  input  logic [TMR_W-1:0] lim_i,
  output logic             fault_o
);
  logic             over;
  logic [TMR_W-1:0] run_q;

  assign over = gate_i && (pwr_i > thr_i);

  // run_q = consecutive earlier cycles above threshold, saturating
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          run_q <= '0;
    else if (!over)       run_q <= '0;
    else if (run_q != '1) run_q <= run_q + 1'b1;
  end

  assign fault_o = en_i && over && (run_q >= lim_i);
endmodule

// File: rtl/rf_trip_prio.sv
module rf_trip_prio #(
  parameter int unsigned N  = 27,
  parameter int unsigned CW = $clog2(N + 1)
) (
  input  logic [N-1:0]  req_i,
  output logic [CW-1:0] code_o
);
  always_comb begin
    code_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) code_o = CW'(i + 1);
    end
  end
endmodule

// File: rtl/rf_trip_interlock.sv
module rf_trip_interlock
  import rf_trip_pkg::*;
#(
  parameter int unsigned N_CH  = N_CH_DEF,
  parameter int unsigned N_ARC = N_ARC_DEF,
  parameter int unsigned N_SW  = N_SW_DEF,
  parameter int unsigned PWR_W = 12,
  parameter int unsigned TMR_W = 16,
  localparam int unsigned N_SRC = 1 + N_CH + N_ARC + N_SW,
  localparam int unsigned CW    = code_w(N_SRC)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   gate_i,
  input  logic [N_CH*PWR_W-1:0]  pwr_i,
  input  logic [N_CH*PWR_W-1:0]  thresh_i,
  input  logic [N_CH*TMR_W-1:0]  limit_i,
  input  logic [N_CH-1:0]        ch_en_i,
  input  logic [N_ARC-1:0]       arc_i,
  input  logic [N_ARC-1:0]       arc_en_i,
  input  logic [N_SW-1:0]        sw_i,
  input  logic [N_SW-1:0]        sw_en_i,
  input  logic                   vac_ok_i,
  input  logic                   clear_i,
  output logic                   trip_a_o,
  output logic                   trip_b_o,
  output logic [CW-1:0]          cause_o
);
  logic [N_CH-1:0]  ch_fault;
  logic [N_SRC-1:0] src_fault;
  logic [CW-1:0]    first_code;
  logic             any_fault;
  logic             trip_a_q, trip_b_q;
  logic [CW-1:0]    cause_q;

  for (genvar k = 0; k < N_CH; k++) begin : g_ch
    rf_trip_chan #(.PWR_W(PWR_W), .TMR_W(TMR_W)) u_chan (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .gate_i  (gate_i),
      .en_i    (ch_en_i[k]),
      .pwr_i   (pwr_i[k*PWR_W +: PWR_W]),
      .thr_i   (thresh_i[k*PWR_W +: PWR_W]),
      .lim_i   (limit_i[k*TMR_W +: TMR_W]),
      .fault_o (ch_fault[k])
    );
  end

  // source order sets code and priority: vacuum, channels, arcs, software
  assign src_fault = {sw_i & sw_en_i, arc_i & arc_en_i, ch_fault, ~vac_ok_i};
  assign any_fault = |src_fault;

  rf_trip_prio #(.N(N_SRC), .CW(CW)) u_prio (
    .req_i  (src_fault),
    .code_o (first_code)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cause_q <= '0;
    end else if (!trip_a_q) begin
      if (any_fault) cause_q <= first_code;
    end else if (clear_i && !any_fault) begin
      cause_q <= '0;
    end
  end

  // two independent latches feed the redundant lines
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        trip_a_q <= 1'b0;
    else if (any_fault)                 trip_a_q <= 1'b1;
    else if (clear_i)                   trip_a_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        trip_b_q <= 1'b0;
    else if (any_fault)                 trip_b_q <= 1'b1;
    else if (clear_i)                   trip_b_q <= 1'b0;
  end

  assign trip_a_o = trip_a_q;
  assign trip_b_o = trip_b_q;
  assign cause_o  = cause_q;
endmodule

// File: rtl/rf_trip_interlock_chk.sv
module rf_trip_interlock_chk #(
  parameter int unsigned CW = 5
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          vac_ok_i,
  input logic          clear_i,
  input logic          any_fault_i,
  input logic          trip_a_i,
  input logic          trip_b_i,
  input logic [CW-1:0] cause_i
);
  a_r9_lines_agree: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trip_a_i == trip_b_i);

  a_r7_vacuum_trips: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vac_ok_i |=> trip_a_i);

  a_r8_trip_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trip_a_i && !clear_i |=> trip_a_i);

  a_r8_clear_blocked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trip_a_i && any_fault_i |=> trip_a_i);

  a_r8_clear_releases: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trip_a_i && clear_i && !any_fault_i |=> !trip_a_i);

  a_r10_cause_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trip_a_i && !clear_i |=> $stable(cause_i));

  a_r10_cause_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trip_a_i == (cause_i != '0));
endmodule

bind rf_trip_interlock rf_trip_interlock_chk #(.CW(CW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .vac_ok_i    (vac_ok_i),
  .clear_i     (clear_i),
  .any_fault_i (any_fault),
  .trip_a_i    (trip_a_o),
  .trip_b_i    (trip_b_o),
  .cause_i     (cause_o)
);

// File: tb/rf_trip_interlock_tb_top.sv
module rf_trip_interlock_tb_top;
  localparam int NC = 8, NA = 14, NS = 4, PW = 12, TW = 16, CW = 5;
  localparam int SAT = (1 << TW) - 1;

  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic              gate, vac_ok, clear;
  logic [NC*PW-1:0]  pwr_v, thr_v;
  logic [NC*TW-1:0]  lim_v;
  logic [NC-1:0]     ch_en;
  logic [NA-1:0]     arc, arc_en;
  logic [NS-1:0]     sw, sw_en;
  logic              trip_a, trip_b;
  logic [CW-1:0]     cause;

  int pwr[NC], thr[NC], lim[NC];

  always_comb begin
    for (int k = 0; k < NC; k++) begin
      pwr_v[k*PW +: PW] = PW'(pwr[k]);
      thr_v[k*PW +: PW] = PW'(thr[k]);
      lim_v[k*TW +: TW] = TW'(lim[k]);
    end
  end

  rf_trip_interlock dut_i (
    .clk_i(clk), .rst_ni(rst_n), .gate_i(gate), .pwr_i(pwr_v),
    .thresh_i(thr_v), .limit_i(lim_v), .ch_en_i(ch_en), .arc_i(arc),
    .arc_en_i(arc_en), .sw_i(sw), .sw_en_i(sw_en), .vac_ok_i(vac_ok),
    .clear_i(clear), .trip_a_o(trip_a), .trip_b_o(trip_b), .cause_o(cause)
  );

  int vectors = 0, fails = 0;
  string cur = "R11";
  int m_run[NC];
  int m_trip = 0, m_cause = 0;

  task automatic check(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic model_edge();
    int code = 0;
    bit over;
    if (!vac_ok) code = 1;
    for (int k = 0; k < NC && code == 0; k++) begin
      over = gate && (pwr[k] > thr[k]);
      if (ch_en[k] && over && m_run[k] >= lim[k]) code = 2 + k;
    end
    for (int j = 0; j < NA && code == 0; j++)
      if (arc[j] && arc_en[j]) code = 10 + j;
    for (int s = 0; s < NS && code == 0; s++)
      if (sw[s] && sw_en[s]) code = 24 + s;
    if (m_trip == 0) begin
      if (code != 0) begin m_trip = 1; m_cause = code; end
    end else if (clear && code == 0) begin
      m_trip = 0; m_cause = 0;
    end
    for (int k = 0; k < NC; k++) begin
      over = gate && (pwr[k] > thr[k]);
      if (!over) m_run[k] = 0;
      else if (m_run[k] < SAT) m_run[k]++;
    end
  endtask

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      model_edge();
      @(negedge clk);
      check({cur, " trip_a"}, int'(trip_a), m_trip);
      check({cur, " trip_b (R9)"}, int'(trip_b), m_trip);
      check({cur, " cause"}, int'(cause), m_cause);
      clear = 1'b0;
    end
  endtask

  task automatic do_clear();
    clear = 1'b1;
    step();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    gate = 0; vac_ok = 1; clear = 0;
    ch_en = '1; arc = '0; arc_en = '1; sw = '0; sw_en = '1;
    for (int k = 0; k < NC; k++) begin
      pwr[k] = 100; thr[k] = 1000; lim[k] = 3; m_run[k] = 0;
    end
    repeat (2) @(negedge clk);
    check("R11 trip_a", int'(trip_a), 0);
    check("R11 cause", int'(cause), 0);
    rst_n = 1'b1;
    step(2);

    cur = "R1"; gate = 1; pwr[2] = 1500;
    step(3);
    check("R1 no trip after 3", int'(trip_a), 0);
    step();
    check("R1 trip after 4", int'(trip_a), 1);
    check("R10 cause ch2", int'(cause), 4);
    pwr[2] = 100; step(); do_clear();
    check("R8 released", int'(trip_a), 0);

    cur = "R1"; lim[6] = 0; pwr[6] = 1001; step();
    check("R1 limit 0", int'(trip_a), 1);
    pwr[6] = 100; lim[6] = 3; do_clear();

    cur = "R2"; pwr[5] = 1200; step(3);
    pwr[5] = 1000; step();
    pwr[5] = 1200; step(3);
    check("R2 equal resets run", int'(trip_a), 0);
    step();
    check("R2 trips after fresh run", int'(trip_a), 1);
    pwr[5] = 100; do_clear();

    cur = "R3"; gate = 0; pwr[0] = 4000; step(10);
    check("R3 gate low ignored", int'(trip_a), 0);
    gate = 1; step(2); gate = 0; step(); gate = 1; step(3);
    check("R3 gate drop resets run", int'(trip_a), 0);
    pwr[0] = 100; step();

    cur = "R4"; ch_en[1] = 0; pwr[1] = 2000; step(10);
    check("R4 masked channel", int'(trip_a), 0);
    ch_en[1] = 1; step();
    check("R4 enable trips at once", int'(trip_a), 1);
    check("R10 cause ch1", int'(cause), 3);
    pwr[1] = 100; do_clear();

    cur = "R5"; arc_en[7] = 0; arc[7] = 1; step(3);
    check("R5 masked arc", int'(trip_a), 0);
    arc_en[7] = 1; step();
    check("R10 cause arc7", int'(cause), 17);
    cur = "R8"; do_clear();
    check("R8 clear blocked by fault", int'(trip_a), 1);
    arc[7] = 0; step(); do_clear();
    check("R8 clear after fault gone", int'(trip_a), 0);

    cur = "R6"; sw_en[2] = 0; sw[2] = 1; step(3);
    check("R6 masked sw", int'(trip_a), 0);
    sw_en[2] = 1; step();
    check("R10 cause sw2", int'(cause), 26);
    sw[2] = 0; sw_en = '1; do_clear();

    cur = "R7"; ch_en = '0; arc_en = '0; sw_en = '0; vac_ok = 0; step();
    check("R7 vacuum unmaskable", int'(trip_a), 1);
    check("R10 cause vacuum", int'(cause), 1);
    vac_ok = 1; do_clear();
    ch_en = '1; arc_en = '1; sw_en = '1;

    cur = "R10"; arc[3] = 1; sw[0] = 1; step();
    check("R10 lowest code wins", int'(cause), 13);
    arc[3] = 0; sw[0] = 0; arc[0] = 1; step(2);
    check("R10 first cause kept", int'(cause), 13);
    arc[0] = 0; do_clear();
    step(2);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule